// File: doc/BRIEF.md
# Return-to-Zero Pulse Pattern Receiver and Comparator

This block listens to a return-to-zero pulse line once the local transmitter has finished a frame. After it is armed, the first rising edge on the line is taken as the start of the received pattern. That first bit is always a 1. Every later bit is recovered by sampling the line at a fixed offset inside each bit slot. The slot period and the sampling offset are counted in clock cycles from that first edge. With a 40 MHz clock the defaults give 80-cycle (2 us) slots, sampled 10 cycles in, which is the middle of a 0.5 us pulse.

When it is armed, the block latches the expected pattern and the length, from 1 up to `MAX_BITS`. Once that many bits have been captured, it shows the captured word, strobes `valid_o` for one cycle and reports whether every bit within the length agrees with the expected pattern. If no edge arrives within `TMO_CYC` cycles of arming, it reports a timeout instead. The timeout is tied to the end of the 512 us frame, so a result is always ready before the next frame starts.

Top module: `pulse_rx_cmp`

## Requirements
- R1: After reset, `valid_o`, `match_o` and `timeout_o` are 0 and `pat_o` is all zeros.
- R2: `pulse_i` passes through a two-flop synchroniser. Reception starts only at a rising edge that follows an accepted arm. Pulses seen while the block is not armed produce no result.
- R3: Slot k starts `k*SLOT_CYC` cycles after the start edge. For k >= 1, bit k is the line level `SAMPLE_OFS` cycles into slot k. Bit k of `pat_o` holds slot k, and bits at or above the length are 0.
- R4: After the last bit is captured, `valid_o` is high for exactly one cycle. `pat_o`, `match_o` and `timeout_o` hold their values until the next result.
- R5: `match_o` is 1 only when bits 0 to len-1 of the captured pattern equal the same bits of the expected pattern latched at arm. Expected bits at or above the length are ignored.
- R6: Bit 0 of a captured (non-timeout) result is always 1.
- R7: If no start edge arrives within `TMO_CYC` cycles after arming, the block gives one `valid_o` pulse with `timeout_o`=1, `match_o`=0 and `pat_o`=0. No timeout result appears before that point.
- R8: `arm_i` is ignored while the block is waiting for an edge or capturing. It is accepted again only once the current result has been delivered.
- R9: Lengths at both ends of the working range (15 and 30 bits) are captured and compared correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pulse_i | input | 1 | Asynchronous return-to-zero pulse line |
| arm_i | input | 1 | Arm strobe from the transmitter's done signal |
| exp_pat_i | input | MAX_BITS | Expected pattern, slot k at bit k |
| len_i | input | LEN_W | Number of bits to capture (1..MAX_BITS) |
| pat_o | output | MAX_BITS | Captured pattern |
| valid_o | output | 1 | One-cycle result strobe |
| match_o | output | 1 | Captured pattern equals expected |
| timeout_o | output | 1 | No start edge before the timeout |

## Verification
The bench builds the block with `SLOT_CYC`=8, `SAMPLE_OFS`=1 and `TMO_CYC`=100, and keeps `MAX_BITS` at 30. It drives pulses 2 cycles wide, so a full 30-bit frame and a timeout each take only a few hundred cycles. With these short counts the bench can check a timeout boundary on both sides, a re-arm during a capture, mismatches that differ in a single bit, and expected-pattern bits that lie above the length, all in a short run.

// File: rtl/pulse_rx_pkg.sv
package pulse_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAP  = 2'd2,
    ST_DONE = 2'd3
  } rx_state_e;
endpackage

// File: rtl/pulse_rx_sync.sv
module pulse_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[0], d_i};
  end
  assign q_o = ff_q[1];
endmodule

// File: rtl/pulse_rx_slot_timer.sv
module pulse_rx_slot_timer #(
  parameter int SLOT_CYC   = 80,
  parameter int SAMPLE_OFS = 10,
  parameter int IDX_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             samp_o
);
  localparam int CYC_W = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYC - 1);
  localparam logic [CYC_W-1:0] CYC_SAMP = CYC_W'(SAMPLE_OFS);

  logic [CYC_W-1:0] cyc_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      idx_q <= '0;
    end else if (start_i) begin
      // start edge is cycle 0 of slot 0
      cyc_q <= CYC_W'(1);
      idx_q <= '0;
    end else if (run_i) begin
      if (cyc_q == CYC_LAST) begin
        cyc_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign idx_o  = idx_q;
  assign samp_o = run_i && (cyc_q == CYC_SAMP) && (idx_q != '0);

  AST_CYC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q <= CYC_LAST); // R3
endmodule

// File: rtl/pulse_rx_cmp.sv
module pulse_rx_cmp #(
  parameter int MAX_BITS   = 30,
  parameter int SLOT_CYC   = 80,
  parameter int SAMPLE_OFS = 10,
  parameter int TMO_CYC    = 20000,
  localparam int LEN_W     = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pulse_i,
  input  logic                arm_i,
  input  logic [MAX_BITS-1:0] exp_pat_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic [MAX_BITS-1:0] pat_o,
  output logic                valid_o,
  output logic                match_o,
  output logic                timeout_o
);
  import pulse_rx_pkg::*;

  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

  rx_state_e          state_q;
  logic               line_s, line_prev_q, rise;
  logic [MAX_BITS-1:0] pat_q, exp_q, len_mask;
  logic [LEN_W-1:0]   len_q, idx;
  logic [TMO_W-1:0]   tmo_q;
  logic               tmo_flag_q, samp, start;

  pulse_rx_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pulse_i), .q_o(line_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_prev_q <= 1'b0;
    else         line_prev_q <= line_s;
  end

  assign rise  = line_s && !line_prev_q;
  assign start = (state_q == ST_WAIT) && rise;

  pulse_rx_slot_timer #(
    .SLOT_CYC(SLOT_CYC), .SAMPLE_OFS(SAMPLE_OFS), .IDX_W(LEN_W)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .run_i(state_q == ST_CAP), .idx_o(idx), .samp_o(samp)
  );

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++) len_mask[i] = (i < int'(len_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pat_q      <= '0;
      exp_q      <= '0;
      len_q      <= '0;
      tmo_q      <= '0;
      tmo_flag_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (arm_i) begin
          state_q    <= ST_WAIT;
          pat_q      <= '0;
          exp_q      <= exp_pat_i;
          len_q      <= len_i;
          tmo_q      <= '0;
          tmo_flag_q <= 1'b0;
        end
        ST_WAIT: begin
          if (rise) begin
            pat_q[0] <= 1'b1;
            state_q  <= (len_q <= LEN_W'(1)) ? ST_DONE : ST_CAP;
          end else if (tmo_q == TMO_LAST) begin
            tmo_flag_q <= 1'b1;
            state_q    <= ST_DONE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        ST_CAP: if (samp) begin
          pat_q[idx] <= line_s;
          if (idx == len_q - 1'b1) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      match_o   <= 1'b0;
      timeout_o <= 1'b0;
      pat_o     <= '0;
    end else begin
      valid_o <= (state_q == ST_DONE);
      if (state_q == ST_DONE) begin
        pat_o     <= pat_q;
        timeout_o <= tmo_flag_q;
        match_o   <= !tmo_flag_q && (((pat_q ^ exp_q) & len_mask) == '0);
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R4
  AST_TMO_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && timeout_o) |-> (!match_o && pat_o == '0)); // R7
  AST_SLOT0_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !timeout_o) |-> pat_o[0]); // R6
  AST_CAP_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAP) |=> (state_q == ST_CAP || state_q == ST_DONE)); // R8
  AST_WAIT_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && arm_i && !rise && tmo_q != '0) |=> $stable(len_q)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAP) |-> (idx < len_q)); // R3
  AST_STABLE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pat_o) || $past(state_q) == ST_DONE); // R4
endmodule

// File: tb/pulse_rx_cmp_tb.sv
module pulse_rx_cmp_tb;
  localparam int MAX_BITS = 30;
  localparam int SLOT     = 8;
  localparam int OFS      = 1;
  localparam int TMO      = 100;
  localparam int PW       = 2;
  localparam int LEN_W    = $clog2(MAX_BITS + 1);

  logic clk = 1'b0, rst_n = 1'b0, pulse = 1'b0, arm = 1'b0;
  logic [MAX_BITS-1:0] exp_pat = '0;
  logic [LEN_W-1:0]    len = '0;
  logic [MAX_BITS-1:0] pat;
  logic valid, match, tmo;

  int n_chk = 0, n_bad = 0, n_valid = 0;
  logic [MAX_BITS-1:0] got_pat;
  logic got_match, got_tmo;

  always #2.5 clk = ~clk;

  pulse_rx_cmp #(
    .MAX_BITS(MAX_BITS), .SLOT_CYC(SLOT), .SAMPLE_OFS(OFS), .TMO_CYC(TMO)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .arm_i(arm),
    .exp_pat_i(exp_pat), .len_i(len), .pat_o(pat), .valid_o(valid),
    .match_o(match), .timeout_o(tmo)
  );

  always @(negedge clk) if (valid) begin
    n_valid   <= n_valid + 1;
    got_pat   <= pat;
    got_match <= match;
    got_tmo   <= tmo;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm(input logic [MAX_BITS-1:0] e, input int l);
    @(negedge clk);
    exp_pat = e; len = LEN_W'(l); arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  // rearm_slot >= 0 pulses arm_i during that slot
  task automatic send(input logic [MAX_BITS-1:0] p, input int l, input int rearm_slot);
    for (int k = 0; k < l; k++)
      for (int c = 0; c < SLOT; c++) begin
        pulse = p[k] && (c < PW);
        arm   = (k == rearm_slot) && (c == 3);
        @(negedge clk);
      end
    pulse = 1'b0; arm = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", 64'(valid), 0);
    check("R1 match", 64'(match), 0);
    check("R1 timeout", 64'(tmo), 0);
    check("R1 pat", 64'(pat), 0);
  endtask

  task automatic t_frame(input string req, input logic [MAX_BITS-1:0] p, input int l,
                         input logic [MAX_BITS-1:0] e, input logic exp_m);
    int v0;
    logic [MAX_BITS-1:0] m;
    m = (l >= MAX_BITS) ? '1 : ((MAX_BITS'(1) << l) - 1'b1);
    do_arm(e, l);
    idle(3);
    v0 = n_valid;
    send(p, l, -1);
    idle(4);
    check({req, " R4 one valid"}, 64'(n_valid - v0), 1);
    check({req, " R3 pattern"}, 64'(got_pat), 64'(p & m));
    check({req, " R5 match"}, 64'(got_match), 64'(exp_m));
    check({req, " R6 bit0"}, 64'(got_pat[0]), 1);
    check({req, " R7 no timeout"}, 64'(got_tmo), 0);
    check({req, " R4 hold"}, 64'(pat), 64'(p & m));
  endtask

  task automatic t_timeout;
    int v0;
    do_arm('1, 20);
    v0 = n_valid;
    idle(TMO - 6);
    check("R7 not early", 64'(n_valid - v0), 0);
    idle(12);
    check("R7 one valid", 64'(n_valid - v0), 1);
    check("R7 timeout flag", 64'(got_tmo), 1);
    check("R7 match low", 64'(got_match), 0);
    check("R7 pat zero", 64'(got_pat), 0);
  endtask

  task automatic t_no_arm;
    int v0;
    v0 = n_valid;
    send(30'h155, 15, -1);
    idle(TMO + 10);
    check("R2 no arm no result", 64'(n_valid - v0), 0);
  endtask

  task automatic t_rearm;
    int v0;
    logic [MAX_BITS-1:0] p;
    p = 30'h2A5A_C3F1;
    do_arm(p, 30);
    idle(2);
    v0 = n_valid;
    send(p, 30, 10);
    idle(TMO + 20);
    check("R8 rearm ignored", 64'(n_valid - v0), 1);
    check("R8 result kept", 64'(got_pat), 64'(p));
    check("R8 match", 64'(got_match), 1);
  endtask

  initial begin
    fork
      begin
        idle(3);
        t_reset;
        rst_n = 1'b1;
        idle(3);
        t_no_arm;                                             // R2
        t_frame("R9 len15", 30'h4E35, 15, 30'h4E35, 1'b1);
        t_frame("R9 len30", 30'h3F0F_5A5B, 30, 30'h3F0F_5A5B, 1'b1);
        t_frame("R5 onebit", 30'h4E35, 15, 30'h4E31, 1'b0);
        t_frame("R5 lastbit", 30'h0001, 15, 30'h4001, 1'b0);
        t_frame("R5 above len", 30'h7FFF, 15, 30'h3FFF_FFFF, 1'b1);
        t_frame("R3 alternating", 30'h1555_5555, 30, 30'h1555_5555, 1'b1);
        t_frame("R3 only first", 30'h1, 30, 30'h1, 1'b1);
        t_frame("R3 len1", 30'h1, 1, 30'h1, 1'b1);
        t_timeout;
        t_rearm;
        t_frame("R2 after rearm", 30'h5A5B, 16, 30'h5A5B, 1'b1);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule